// File: doc/BRIEF.md
# Privilege-Aware Local Interrupt Selector

This block decides which local interrupt a processor core should take next, or reports that none is ready. It looks at the pending and enable masks together with the delegation mask. It also looks at the current privilege level and at the two global interrupt-enable bits, one for machine level and one for supervisor level. From these it produces a valid flag and the cause number of the winning interrupt. The trap-entry logic of the core uses the pair to decide whether to redirect the pipeline.

Each interrupt is first qualified by its own pending and enable bits. It is then gated by a privilege-dependent global enable. An interrupt that is not delegated answers to the machine-level enable. A delegated interrupt answers to the supervisor-level enable. Among the survivors, the lowest bit index wins.

The outputs pass through a parameterised output stage. By default this is one register stage, so every input change appears at the outputs exactly one clock later. Setting the stage count to zero gives a purely combinational path.

Top module: `irq_select_top`

## Requirements
- R1: An interrupt bit is a candidate only when both its pending bit and its enable bit are 1; a pending bit with a clear enable bit never produces `take_o`.
- R2: The machine-level global enable is true when the privilege is below machine (codes 0, 1, 2), or when the privilege is machine (code 3) and `m_gie_i` is 1.
- R3: The supervisor-level global enable is true when the privilege is user (code 0, or code 2 treated as user), or when the privilege is supervisor (code 1) and `s_gie_i` is 1; at machine privilege (code 3) it is always false.
- R4: A candidate whose `deleg_i` bit is 0 is gated by the machine-level enable; a candidate whose `deleg_i` bit is 1 is gated by the supervisor-level enable.
- R5: When several candidates survive gating, `cause_o` is the lowest surviving bit index (bit 0 has the highest priority).
- R6: When no candidate survives, `take_o` is 0 and `cause_o` is 0.
- R7: Privilege code 2 behaves exactly as user privilege (code 0).
- R8: With the default single output stage, outputs reflect the inputs sampled at the previous rising clock edge; while `rst_n` is low, `take_o` and `cause_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset of the output stage |
| pend_i | input | NUM_IRQ (64) | Pending interrupt mask |
| en_i | input | NUM_IRQ (64) | Per-interrupt enable mask |
| deleg_i | input | NUM_IRQ (64) | Delegation mask, 1 = handled at supervisor level |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 2 treated as user, 3 machine |
| m_gie_i | input | 1 | Machine-level global interrupt enable |
| s_gie_i | input | 1 | Supervisor-level global interrupt enable |
| take_o | output | 1 | An interrupt is ready to be taken |
| cause_o | output | CAUSE_W (6) | Index of the chosen interrupt, 0 when `take_o` is low |

## Verification
The only state in the block is the output register. A wrong gating term or a wrong priority scan shows up as a wrong `take_o` or `cause_o` one clock after the offending input pattern is applied. Nothing is hidden for longer than that single cycle. The stimulus therefore changes inputs every cycle and compares each result against a model one edge later. This exposes gating faults, priority-order faults and latency faults alike. It also holds reset in the middle of a run to confirm the outputs clear.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

   typedef enum logic [1:0] {
      LVL_USER  = 2'd0,
      LVL_SUPER = 2'd1,
      LVL_RSVD  = 2'd2,
      LVL_MACH  = 2'd3
   } lvl_e;

   // Reserved level folds onto user level.
   function automatic lvl_e fold_level(input logic [1:0] raw);
      lvl_e l;
      l = lvl_e'(raw);
      if (l == LVL_RSVD) l = LVL_USER;
      return l;
   endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
   import irq_sel_pkg::*;
#(
   parameter int NUM_IRQ = 64
) (
   input  logic [NUM_IRQ-1:0] pend_i,
   input  logic [NUM_IRQ-1:0] en_i,
   input  logic [NUM_IRQ-1:0] deleg_i,
   input  logic [1:0]         priv_i,
   input  logic               m_gie_i,
   input  logic               s_gie_i,
   output logic [NUM_IRQ-1:0] ready_o
);

   lvl_e lvl;
   logic m_open;
   logic s_open;
   logic [NUM_IRQ-1:0] cand;

   always_comb begin
      lvl    = fold_level(priv_i);
      m_open = (lvl != LVL_MACH) || m_gie_i;
      s_open = (lvl == LVL_USER) || ((lvl == LVL_SUPER) && s_gie_i);
   end

   assign cand = pend_i & en_i;

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_bit
      assign ready_o[g] = cand[g] & (deleg_i[g] ? s_open : m_open);
   end

endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
   parameter int NUM_IRQ = 64,
   parameter int IDX_W   = 6
) (
   input  logic [NUM_IRQ-1:0] vec_i,
   output logic               hit_o,
   output logic [IDX_W-1:0]   idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign hit_o = |vec_i;

endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
   parameter int W      = 7,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES == 0) begin : g_comb
      assign q_o = d_i;
   end else begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= '0;
         else        q_r <= d_i;
      end
      assign q_o = q_r;
   end

endmodule

// File: rtl/irq_select_top.sv
module irq_select_top #(
   parameter int NUM_IRQ    = 64,
   parameter int OUT_STAGES = 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_IRQ-1:0]         pend_i,
   input  logic [NUM_IRQ-1:0]         en_i,
   input  logic [NUM_IRQ-1:0]         deleg_i,
   input  logic [1:0]                 priv_i,
   input  logic                       m_gie_i,
   input  logic                       s_gie_i,
   output logic                       take_o,
   output logic [$clog2(NUM_IRQ)-1:0] cause_o
);

   localparam int CAUSE_W = $clog2(NUM_IRQ);
   localparam int PKT_W   = CAUSE_W + 1;

   if (NUM_IRQ < 2 || NUM_IRQ > 1024) begin : g_bad_num
      $error("irq_select_top: NUM_IRQ out of range");
   end
   if (OUT_STAGES != 0 && OUT_STAGES != 1) begin : g_bad_stage
      $error("irq_select_top: OUT_STAGES must be 0 or 1");
   end

   logic [NUM_IRQ-1:0] ready;
   logic               hit;
   logic [CAUSE_W-1:0] idx;
   logic [PKT_W-1:0]   pkt_d;
   logic [PKT_W-1:0]   pkt_q;

   irq_gate #(.NUM_IRQ(NUM_IRQ)) u_gate (
      .pend_i  (pend_i),
      .en_i    (en_i),
      .deleg_i (deleg_i),
      .priv_i  (priv_i),
      .m_gie_i (m_gie_i),
      .s_gie_i (s_gie_i),
      .ready_o (ready)
   );

   irq_lsb_pick #(.NUM_IRQ(NUM_IRQ), .IDX_W(CAUSE_W)) u_pick (
      .vec_i (ready),
      .hit_o (hit),
      .idx_o (idx)
   );

   assign pkt_d = {hit, idx};

   irq_out_stage #(.W(PKT_W), .STAGES(OUT_STAGES)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pkt_d),
      .q_o   (pkt_q)
   );

   assign take_o  = pkt_q[PKT_W-1];
   assign cause_o = pkt_q[CAUSE_W-1:0];

endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
   parameter int NUM_IRQ    = 64,
   parameter int CAUSE_W    = 6,
   parameter int OUT_STAGES = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_IRQ-1:0] pend_i,
   input logic [NUM_IRQ-1:0] en_i,
   input logic [NUM_IRQ-1:0] deleg_i,
   input logic [1:0]         priv_i,
   input logic               m_gie_i,
   input logic               s_gie_i,
   input logic               take_o,
   input logic [CAUSE_W-1:0] cause_o
);

   // Copies of the inputs from the previous edge, and an arm flag that
   // is set only once one full edge has passed out of reset.
   logic               armed;
   logic [NUM_IRQ-1:0] cand_p;
   logic [NUM_IRQ-1:0] deleg_p;
   logic [1:0]         priv_p;
   logic               m_gie_p;
   logic               s_gie_p;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         cand_p  <= '0;
         deleg_p <= '0;
         priv_p  <= '0;
         m_gie_p <= 1'b0;
         s_gie_p <= 1'b0;
      end else begin
         armed   <= 1'b1;
         cand_p  <= pend_i & en_i;
         deleg_p <= deleg_i;
         priv_p  <= priv_i;
         m_gie_p <= m_gie_i;
         s_gie_p <= s_gie_i;
      end
   end

   logic won_cand;
   logic won_deleg;
   assign won_cand  = cand_p[cause_o];
   assign won_deleg = deleg_p[cause_o];

   if (OUT_STAGES == 1) begin : g_props
      // R6
      p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !take_o |-> (cause_o == '0));

      // R1
      p_winner_cand_r1: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         take_o |-> won_cand);

      // R2
      p_mach_closed_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         (priv_p == 2'd3 && !m_gie_p) |-> !take_o);

      // R3
      p_mach_no_deleg_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         (take_o && priv_p == 2'd3) |-> !won_deleg);

      // R4
      p_super_closed_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
         (take_o && priv_p == 2'd1 && !s_gie_p) |-> !won_deleg);

      // R7
      p_user_open_r7: assert property (@(posedge clk) disable iff (!rst_n)
         ((priv_i == 2'd0 || priv_i == 2'd2) && (|(pend_i & en_i))) |=> take_o);
   end

endmodule

bind irq_select_top irq_select_chk #(
   .NUM_IRQ    (NUM_IRQ),
   .CAUSE_W    (CAUSE_W),
   .OUT_STAGES (OUT_STAGES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pend_i  (pend_i),
   .en_i    (en_i),
   .deleg_i (deleg_i),
   .priv_i  (priv_i),
   .m_gie_i (m_gie_i),
   .s_gie_i (s_gie_i),
   .take_o  (take_o),
   .cause_o (cause_o)
);

// File: tb/tb_irq_select_top.sv
`timescale 1ns/1ps
module tb_irq_select_top;

   localparam int N  = 64;
   localparam int CW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pend_i = '0;
   logic [N-1:0]  en_i = '0;
   logic [N-1:0]  deleg_i = '0;
   logic [1:0]    priv_i = '0;
   logic          m_gie_i = 1'b0;
   logic          s_gie_i = 1'b0;
   logic          take_o;
   logic [CW-1:0] cause_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   irq_select_top #(.NUM_IRQ(N), .OUT_STAGES(1)) dut (
      .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .en_i(en_i),
      .deleg_i(deleg_i), .priv_i(priv_i), .m_gie_i(m_gie_i),
      .s_gie_i(s_gie_i), .take_o(take_o), .cause_o(cause_o)
   );

   typedef struct {
      logic          take;
      logic [CW-1:0] cause;
      string         tag;
   } exp_t;

   exp_t sb[$];

   // Reference from the requirements.
   function automatic exp_t model(input logic [N-1:0] p, input logic [N-1:0] e,
                                  input logic [N-1:0] d, input logic [1:0] pv,
                                  input logic mg, input logic sg, input string tag);
      exp_t r;
      logic is_m, is_s, is_u, men, sen;
      is_m = (pv == 2'd3);
      is_s = (pv == 2'd1);
      is_u = (pv == 2'd0) || (pv == 2'd2);
      men  = !is_m || mg;
      sen  = is_u || (is_s && sg);
      r.take = 1'b0; r.cause = '0; r.tag = tag;
      for (int i = 0; i < N; i++) begin
         if (!r.take && p[i] && e[i] && (d[i] ? sen : men)) begin
            r.take  = 1'b1;
            r.cause = CW'(i);
         end
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [CW:0] act, input logic [CW:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual take=%0b cause=%0d expected take=%0b cause=%0d",
                  tag, act[CW], act[CW-1:0], exp[CW], exp[CW-1:0]);
      end
   endtask

   // Driver: applies one vector at a falling edge and queues its expectation.
   task automatic drive(input logic [N-1:0] p, input logic [N-1:0] e,
                        input logic [N-1:0] d, input logic [1:0] pv,
                        input logic mg, input logic sg, input string tag);
      @(negedge clk);
      pend_i = p; en_i = e; deleg_i = d; priv_i = pv; m_gie_i = mg; s_gie_i = sg;
      sb.push_back(model(p, e, d, pv, mg, sg, tag));
   endtask

   // Monitor: one register stage, so result is compared just after the next rising edge (R8).
   always @(posedge clk) begin
      #1;
      if (rst_n && sb.size() > 0) begin
         exp_t x;
         x = sb.pop_front();
         check(x.tag, {take_o, cause_o}, {x.take, x.cause});
      end
   end

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0] lf;
      repeat (3) @(negedge clk);
      check("R8 reset state", {take_o, cause_o}, '0);
      rst_n = 1'b1;

      drive(64'h20, 64'h0, 64'h0, 2'd0, 1'b0, 1'b0, "R1 pending without enable");
      drive(64'h20, 64'h20, 64'h0, 2'd0, 1'b0, 1'b0, "R1 pending and enabled");
      drive(64'h0000_0100_0000_0208, '1, 64'h0, 2'd0, 1'b0, 1'b0, "R5 lowest of 3,9,40");
      drive(64'h80, 64'h80, 64'h0, 2'd3, 1'b0, 1'b1, "R2 machine with m_gie low");
      drive(64'h80, 64'h80, 64'h0, 2'd3, 1'b1, 1'b0, "R2 machine with m_gie high");
      drive(64'h80, 64'h80, 64'h80, 2'd3, 1'b1, 1'b1, "R3 delegated blocked in machine");
      drive(64'h802, 64'h802, 64'h2, 2'd1, 1'b0, 1'b0, "R4 supervisor closed, non-delegated wins");
      drive(64'h2, 64'h2, 64'h2, 2'd1, 1'b0, 1'b0, "R3 supervisor with s_gie low");
      drive(64'h802, 64'h802, 64'h2, 2'd1, 1'b0, 1'b1, "R3 supervisor with s_gie high");
      drive(64'h800, 64'h800, 64'h0, 2'd1, 1'b0, 1'b0, "R2 below machine ignores m_gie");
      drive(64'h2, 64'h2, 64'h2, 2'd2, 1'b0, 1'b0, "R7 code 2 acts as user");
      drive(64'h2, 64'h2, 64'h2, 2'd0, 1'b0, 1'b0, "R3 user opens delegated");
      drive(64'h8000_0000_0000_0000, '1, 64'h0, 2'd0, 1'b0, 1'b0, "R5 top bit only");
      drive(64'h8000_0000_0000_0001, '1, 64'h0, 2'd0, 1'b0, 1'b0, "R5 bit 0 beats bit 63");
      drive(64'h0, '1, '1, 2'd0, 1'b1, 1'b1, "R6 nothing pending");
      drive(64'h3, 64'h3, 64'h1, 2'd3, 1'b1, 1'b1, "R4 machine skips delegated bit 0");

      lf = 64'hACE1_2345_6789_BEEF;
      for (int k = 0; k < 300; k++) begin
         logic [63:0] a, b, c;
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]}; a = lf;
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]}; b = lf;
         lf = {lf[62:0], lf[63] ^ lf[62] ^ lf[60] ^ lf[59]}; c = lf;
         drive(a & b & {lf[7:0], lf[63:8]}, b | c, c, lf[1:0], lf[2], lf[3],
               "R4 R5 mixed pattern");
      end

      @(negedge clk);
      @(negedge clk);
      drive(64'h10, 64'h10, 64'h0, 2'd0, 1'b0, 1'b0, "R8 before reset");
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R8 reset clears outputs", {take_o, cause_o}, '0);
      @(negedge clk);
      rst_n = 1'b1;
      drive(64'h10, 64'h10, 64'h0, 2'd0, 1'b0, 1'b0, "R8 after reset");
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule